// File: doc/BRIEF.md
# Symbol-Counted Receive Timeout Timer

This block supplies the receive timeout for a packet radio controller. It holds the controller's operating mode (standby, single-shot receive or continuous receive) and, whenever a receive mode is entered, counts symbol ticks from zero. When the count reaches a programmed limit without a valid packet, it raises a sticky timeout flag. The resulting window is the programmed value times the symbol period.

What happens on expiry depends on the mode. In single-shot receive, expiry sends the controller back to standby. Single-shot receive then cannot be entered again until software clears the flag. In continuous receive, expiry only sets the flag. The receiver stays active, and the counter restarts so that later windows can expire again. Software clears the flag with a write-one-to-clear pulse while reception continues.

Top module: `rx_tmo_timer`

## Requirements
- R1: After reset, `mode_o` reads standby (code 0) and `timeout_flag_o` is 0.
- R2: Mode codes are 0 standby, 1 single-shot receive, 2 continuous receive and 3 reserved. A request with `req_valid_i` high takes effect at the next clock edge. A request with code 3 leaves the mode unchanged.
- R3: Entering a receive mode clears the symbol count. Expiry happens at the clock edge of the N-th `sym_tick_i` counted after entry, where N is `timeout_val_i`. Ticks seen in standby are not counted.
- R4: On expiry in single-shot receive, `mode_o` returns to standby and `timeout_flag_o` is set at the same edge.
- R5: While `timeout_flag_o` is 1, a request for single-shot receive is refused and the mode stays unchanged.
- R6: On expiry in continuous receive, the flag is set and the mode stays continuous. The count restarts, so the next expiry comes after another N ticks.
- R7: The flag stays set until a `flag_clr_i` pulse. A clear in the same cycle as an expiry leaves the flag at 0.
- R8: In single-shot receive, `pkt_ok_i` stops the timer, so later ticks cause no expiry. A packet in the same cycle as the final tick also prevents the expiry.
- R9: Leaving receive mode discards the count, so a new entry needs a full N ticks.
- R10: A `timeout_val_i` of 0 disables expiry in both receive modes.
- R11: Requesting the receive mode that is already active has no effect on the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_tick_i | input | 1 | One-cycle pulse per elapsed symbol period |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 2 | Requested mode code |
| pkt_ok_i | input | 1 | Valid packet received indication |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the timeout flag |
| timeout_val_i | input | CNT_W | Timeout in symbol periods, 0 disables |
| mode_o | output | 2 | Current mode code |
| timeout_flag_o | output | 1 | Sticky timeout interrupt flag |

## Verification
A wrong symbol count shows up at the ports as a flag, and in single-shot receive also a return to standby, that arrives one or more ticks too early or too late. The per-cycle comparison catches this at the edge of the expected expiry tick. A lost armed state shows up as a missing or spurious expiry after a packet, a re-entry or a continuous re-arm. A mis-handled mode or flag priority shows up within one clock as a wrong `mode_o` or `timeout_flag_o` after a request, a clear or a refused entry.

// File: rtl/rx_tmo_pkg.sv
package rx_tmo_pkg;

   typedef enum logic [1:0] {
      MODE_STBY   = 2'd0,
      MODE_SINGLE = 2'd1,
      MODE_CONT   = 2'd2,
      MODE_RSVD   = 2'd3
   } rx_mode_e;

   function automatic logic is_rx(input rx_mode_e m);
      return (m == MODE_SINGLE) || (m == MODE_CONT);
   endfunction

endpackage

// File: rtl/rx_tmo_modectl.sv
module rx_tmo_modectl
   import rx_tmo_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  rx_mode_e req_mode,
   input  logic     flag_set,
   input  logic     expire,
   output rx_mode_e mode_q,
   output logic     enter_rx,
   output logic     leave_rx
);

   rx_mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      if (expire && mode_q == MODE_SINGLE) begin
         mode_d = MODE_STBY;
      end else if (req_valid) begin
         unique case (req_mode)
            MODE_STBY:   mode_d = MODE_STBY;
            MODE_SINGLE: mode_d = flag_set ? mode_q : MODE_SINGLE;
            MODE_CONT:   mode_d = MODE_CONT;
            default:     mode_d = mode_q;
         endcase
      end
   end

   assign enter_rx = (mode_d != mode_q) && is_rx(mode_d);
   assign leave_rx = (mode_d == MODE_STBY) && is_rx(mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_STBY;
      end else begin
         mode_q <= mode_d;
      end
   end

endmodule

// File: rtl/rx_tmo_symcnt.sv
module rx_tmo_symcnt #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   input  logic             in_rx,
   input  logic             in_single,
   input  logic             pkt_ok,
   input  logic             restart,
   input  logic             leave,
   output logic             expire
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic [CNT_W:0]   cnt_inc;
   logic             running;
   logic             pkt_stop;
   logic             reached;

   assign running  = in_rx && armed_q && (limit != '0);
   assign pkt_stop = in_single && pkt_ok;
   assign cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign reached  = cnt_inc >= {1'b0, limit};
   assign expire   = running && tick && reached && !pkt_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (restart) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (leave) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (pkt_stop) begin
         armed_q <= 1'b0;
      end else if (expire) begin
         cnt_q   <= '0;
      end else if (running && tick && cnt_q != CNT_MAX) begin
         cnt_q   <= cnt_inc[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/rx_tmo_flag.sv
module rx_tmo_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (clr) begin
         flag_q <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
      end
   end

endmodule

// File: rtl/rx_tmo_timer.sv
module rx_tmo_timer
   import rx_tmo_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_tick_i,
   input  logic             req_valid_i,
   input  logic [1:0]       req_mode_i,
   input  logic             pkt_ok_i,
   input  logic             flag_clr_i,
   input  logic [CNT_W-1:0] timeout_val_i,
   output logic [1:0]       mode_o,
   output logic             timeout_flag_o
);

   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_width
      $error("rx_tmo_timer: CNT_W must lie in 1..24");
   end

   rx_mode_e mode_q;
   logic     enter_rx;
   logic     leave_rx;
   logic     tmo_expire;
   logic     flag_q;

   rx_tmo_modectl u_modectl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid_i),
      .req_mode  (rx_mode_e'(req_mode_i)),
      .flag_set  (flag_q),
      .expire    (tmo_expire),
      .mode_q    (mode_q),
      .enter_rx  (enter_rx),
      .leave_rx  (leave_rx)
   );

   rx_tmo_symcnt #(.CNT_W(CNT_W)) u_symcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sym_tick_i),
      .limit     (timeout_val_i),
      .in_rx     (is_rx(mode_q)),
      .in_single (mode_q == MODE_SINGLE),
      .pkt_ok    (pkt_ok_i),
      .restart   (enter_rx),
      .leave     (leave_rx),
      .expire    (tmo_expire)
   );

   rx_tmo_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (tmo_expire),
      .clr    (flag_clr_i),
      .flag_q (flag_q)
   );

   assign mode_o         = mode_q;
   assign timeout_flag_o = flag_q;

endmodule

// File: rtl/rx_tmo_timer_chk.sv
module rx_tmo_timer_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid_i,
   input logic [1:0]       req_mode_i,
   input logic             flag_clr_i,
   input logic [CNT_W-1:0] timeout_val_i,
   input logic [1:0]       mode_o,
   input logic             timeout_flag_o,
   input logic             expire
);

   // R7
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_i |=> !timeout_flag_o);

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_flag_o && !flag_clr_i) |=> timeout_flag_o);

   // R4
   single_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && mode_o == 2'd1 && !flag_clr_i) |=> (mode_o == 2'd0 && timeout_flag_o));

   // R5
   refuse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_mode_i == 2'd1 && timeout_flag_o && !expire) |=> $stable(mode_o));

   // R6
   cont_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && mode_o == 2'd2 && !req_valid_i && !flag_clr_i) |=> (mode_o == 2'd2 && timeout_flag_o));

   // R2
   rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_mode_i == 2'd3 && !expire) |=> $stable(mode_o));

   // R10
   zero_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_val_i == '0) |-> !expire);

   // R3
   stby_no_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0) |-> !expire);

endmodule

bind rx_tmo_timer rx_tmo_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid_i    (req_valid_i),
   .req_mode_i     (req_mode_i),
   .flag_clr_i     (flag_clr_i),
   .timeout_val_i  (timeout_val_i),
   .mode_o         (mode_o),
   .timeout_flag_o (timeout_flag_o),
   .expire         (tmo_expire)
);

// File: tb/rx_tmo_timer_test.sv
module rx_tmo_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sym_tick = 1'b0;
   logic         req_valid = 1'b0;
   logic [1:0]   req_mode = 2'd0;
   logic         pkt_ok = 1'b0;
   logic         flag_clr = 1'b0;
   logic [W-1:0] tmo_val = '0;
   logic [1:0]   mode_o;
   logic         flag_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference model state
   int m_mode = 0;
   int m_flag = 0;
   int m_cnt = 0;
   int m_armed = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_tmo_timer #(.CNT_W(W)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .sym_tick_i     (sym_tick),
      .req_valid_i    (req_valid),
      .req_mode_i     (req_mode),
      .pkt_ok_i       (pkt_ok),
      .flag_clr_i     (flag_clr),
      .timeout_val_i  (tmo_val),
      .mode_o         (mode_o),
      .timeout_flag_o (flag_o)
   );

   // Behavioural reference: evaluates the requirements each clock edge.
   always @(posedge clk) begin
      if (rst_n) begin
         int  lim;
         int  nxt;
         bit  fire;
         bit  counting;
         bit  pkt_halt;
         lim      = int'(tmo_val);
         nxt      = m_mode;
         fire     = 0;
         pkt_halt = (m_mode == 1) && pkt_ok;
         counting = (m_mode != 0) && (m_armed != 0) && (lim != 0) && sym_tick;
         if (counting && !pkt_halt && (m_cnt + 1 >= lim)) fire = 1;
         if (fire && m_mode == 1) nxt = 0;
         else if (req_valid) begin
            if (req_mode == 2'd0) nxt = 0;
            else if (req_mode == 2'd2) nxt = 2;
            else if (req_mode == 2'd1 && m_flag == 0) nxt = 1;
         end
         if (flag_clr) m_flag = 0;
         else if (fire) m_flag = 1;
         if (nxt != m_mode && nxt != 0) begin m_cnt = 0; m_armed = 1; end
         else if (nxt == 0) begin m_cnt = 0; m_armed = 0; end
         else if (pkt_halt) m_armed = 0;
         else if (fire) m_cnt = 0;
         else if (counting) m_cnt = m_cnt + 1;
         m_mode = nxt;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock; compare against model at the falling edge
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      if (rst_n) begin
         chk(int'(mode_o) == m_mode, "model compare mode (R2 R4 R6)", int'(mode_o), m_mode);
         chk(int'(flag_o) == m_flag, "model compare flag (R3 R7)", int'(flag_o), m_flag);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         sym_tick = 1'b1;
         cyc();
      end
      sym_tick = 1'b0;
   endtask

   task automatic request(input logic [1:0] m);
      req_valid = 1'b1;
      req_mode  = m;
      cyc();
      req_valid = 1'b0;
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      cyc();
      flag_clr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(mode_o == 2'd0, "R1 mode after reset", int'(mode_o), 0);
      chk(flag_o == 1'b0, "R1 flag after reset", int'(flag_o), 0);
      rst_n = 1'b1;
      cyc();

      // R3 ticks in standby are not counted
      tmo_val = 10'd4;
      ticks(6);
      chk(flag_o == 1'b0, "R3 no timeout in standby", int'(flag_o), 0);

      // R3 R4 single-shot expiry at the fourth tick
      request(2'd1);
      chk(mode_o == 2'd1, "R2 single entered", int'(mode_o), 1);
      ticks(3);
      chk(flag_o == 1'b0, "R3 no flag after three ticks", int'(flag_o), 0);
      ticks(1);
      chk(flag_o == 1'b1, "R3 flag at fourth tick", int'(flag_o), 1);
      chk(mode_o == 2'd0, "R4 back to standby", int'(mode_o), 0);

      // R5 refused while flagged
      request(2'd1);
      chk(mode_o == 2'd0, "R5 single refused", int'(mode_o), 0);
      // R2 reserved ignored
      request(2'd3);
      chk(mode_o == 2'd0, "R2 reserved code ignored", int'(mode_o), 0);

      // R7 sticky then cleared
      cyc();
      chk(flag_o == 1'b1, "R7 flag sticky", int'(flag_o), 1);
      clear_flag();
      chk(flag_o == 1'b0, "R7 flag cleared", int'(flag_o), 0);

      // R6 continuous expiry and re-arm
      tmo_val = 10'd3;
      request(2'd2);
      ticks(3);
      chk(flag_o == 1'b1, "R6 flag in continuous", int'(flag_o), 1);
      chk(mode_o == 2'd2, "R6 stays continuous", int'(mode_o), 2);
      clear_flag();
      ticks(2);
      chk(flag_o == 1'b0, "R6 no flag before re-armed window", int'(flag_o), 0);
      ticks(1);
      chk(flag_o == 1'b1, "R6 re-armed expiry", int'(flag_o), 1);
      clear_flag();

      // R7 clear in the expiry cycle wins
      ticks(2);
      sym_tick = 1'b1;
      flag_clr = 1'b1;
      cyc();
      sym_tick = 1'b0;
      flag_clr = 1'b0;
      chk(flag_o == 1'b0, "R7 clear beats set", int'(flag_o), 0);
      ticks(3);
      chk(flag_o == 1'b1, "R7 later expiry still counted", int'(flag_o), 1);
      clear_flag();
      request(2'd0);

      // R8 packet stops the single-shot timer
      tmo_val = 10'd4;
      request(2'd1);
      ticks(2);
      pkt_ok = 1'b1;
      cyc();
      pkt_ok = 1'b0;
      ticks(8);
      chk(flag_o == 1'b0, "R8 packet stops timer", int'(flag_o), 0);
      chk(mode_o == 2'd1, "R8 stays in single", int'(mode_o), 1);
      request(2'd0);

      // R8 packet together with final tick
      request(2'd1);
      ticks(3);
      sym_tick = 1'b1;
      pkt_ok = 1'b1;
      cyc();
      sym_tick = 1'b0;
      pkt_ok = 1'b0;
      chk(flag_o == 1'b0, "R8 packet on final tick wins", int'(flag_o), 0);
      request(2'd0);

      // R9 leaving receive discards count
      request(2'd1);
      ticks(3);
      request(2'd0);
      request(2'd1);
      ticks(3);
      chk(flag_o == 1'b0, "R9 count restarted", int'(flag_o), 0);
      ticks(1);
      chk(flag_o == 1'b1, "R9 full window after re-entry", int'(flag_o), 1);
      clear_flag();

      // R11 same-mode request does not restart
      request(2'd1);
      ticks(2);
      request(2'd1);
      ticks(2);
      chk(flag_o == 1'b1, "R11 running count kept", int'(flag_o), 1);
      chk(mode_o == 2'd0, "R11 expiry returned to standby", int'(mode_o), 0);
      clear_flag();

      // R10 zero value disables
      tmo_val = 10'd0;
      request(2'd2);
      ticks(20);
      chk(flag_o == 1'b0, "R10 continuous disabled", int'(flag_o), 0);
      request(2'd1);
      ticks(20);
      chk(flag_o == 1'b0, "R10 single disabled", int'(flag_o), 0);
      chk(mode_o == 2'd1, "R10 single held", int'(mode_o), 1);
      request(2'd0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule